// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a group of DDR SDRAM ranks from the moment power is stable to normal operation. After a start pulse it runs a fixed script of device commands. Between commands it holds waits that are counted in whole units. One unit is a parameter number of microseconds, and a microsecond is a parameter number of clock cycles, so a simulation can shrink every wait without changing the script.

Each device command is broadcast to every populated rank, one rank per clock cycle. A table of cumulative rank end boundaries, in 32 MB steps, tells the walker which ranks hold memory. A rank is hit only when its end lies above the running start. Its bus address is that start scaled by 32 MB.

For mode-register writes, the 12-bit device mode word is placed onto a shifted bus address field. The final switch to normal operation only changes the controller's own state, so it is flagged on the command lines with no rank selected.

The command lines are plain one-cycle strobes with no back-pressure: the physical layer must take a strobe in the cycle it appears. A rank-boundary table and a mode word come in as static inputs. Done, ready and busy are level outputs.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: Command codes on `cmd_o` are: self-refresh 0, NOP 1, precharge-all 2, mode set 3, extended mode set 4, auto-refresh 6, normal operation 7. No strobe ever carries 0 or 5, and `cmd_o` reads 0 when no strobe is present.
- R2: After a start, the commands appear in this order:
  - NOP
  - precharge-all
  - extended mode set
  - mode set with DLL reset
  - precharge-all
  - eight auto-refreshes
  - mode set for normal running
  - normal operation
- R3: The waits are counted from the end of each command's issue phase, and one unit is US_PER_UNIT×CLKS_PER_US cycles:
  - two units pass between the start and the NOP;
  - three units follow the NOP, each precharge-all, the extended mode set, each auto-refresh and the normal-operation step;
  - no wait follows either mode set.
  - A broadcast issue phase lasts NUM_RANKS cycles, and rank r is served in its r-th cycle.
- R4: For each broadcast command, the running start begins at 0. Rank r, whose end boundary is the r-th BND_W-bit field of `rank_end_i`, is strobed only when its end exceeds the running start. The running start then becomes that end. `rank_sel_o` is one-hot on bit r during such a strobe and zero otherwise.
- R5: The strobe address is the running start times 2^25. For the two mode-set commands, mode word bit 11 is added on address bit 13 and mode bits 9:0 on address bits 12:3. For all other commands, address bits 24:0 are zero.
- R6: The mode words used are:
  - the extended mode set uses word 0 (DLL enabled);
  - the first mode set uses `mode_word_i` with bit 8 set (DLL reset);
  - the second mode set uses `mode_word_i` with bit 8 cleared.
- R7: The normal-operation command is one strobe with code 7, `rank_sel_o` zero and `addr_o` zero. It is not broadcast to any rank.
- R8: `init_done_o` rises right after the three-unit wait that follows the normal-operation step. `ready_o` rises 1+5 units of cycles later, and `busy_o` is high from the cycle after a start until `ready_o` rises. `ready_o` implies `init_done_o`.
- R9: A start while busy is ignored and leaves the timeline unchanged. A start while idle or ready restarts the script and clears `init_done_o` and `ready_o` in the next cycle.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| rank_end_i | input | NUM_RANKS*BND_W | Cumulative rank end boundaries in 32 MB units, rank 0 in the low field |
| mode_word_i | input | 12 | Device mode word (burst, order, CAS latency) |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_o | output | 3 | Command code |
| rank_sel_o | output | NUM_RANKS | One-hot rank select |
| addr_o | output | BND_W+25 | Bus address for the strobe |
| init_done_o | output | 1 | Initialization-complete flag |
| ready_o | output | 1 | Sequence finished |
| busy_o | output | 1 | Sequence running |

## Verification
The assertions check the following on every cycle:
- rank selection is one-hot for broadcast strobes and empty otherwise;
- the normal-operation strobe has no rank and no address;
- mode-word bits land only in address bits 13:3;
- ready implies done;
- busy ends only into ready;
- the done flag falls only on a start.

The exact cycle of every strobe, the skipping of unpopulated and out-of-order ranks, the per-rank addresses, the mode words and the immunity to a start while busy can only be shown by the bench. It sweeps every rank-boundary pattern of a small configuration against an arithmetic timeline.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_SELF_REF = 3'd0,
    CMD_NOP      = 3'd1,
    CMD_PRE_ALL  = 3'd2,
    CMD_MRS      = 3'd3,
    CMD_EMRS     = 3'd4,
    CMD_AUTO_REF = 3'd6,
    CMD_NORMAL   = 3'd7
  } dram_cmd_e;

  typedef enum logic [1:0] {
    WORD_NONE,
    WORD_EXT,
    WORD_MODE_RST,
    WORD_MODE_RUN
  } word_sel_e;

  typedef struct packed {
    logic      issue;   // step drives a strobe
    logic      bcast;   // strobe goes to ranks
    dram_cmd_e cmd;
    word_sel_e word;
    logic [2:0] units;  // wait after the step
  } step_t;

  // Script: 0 pre-wait, 1 NOP, 2 PRE, 3 EMRS, 4 MRS rst, 5 PRE,
  // 6.. refreshes, then MRS run, NORMAL, done-flag step.
  function automatic step_t step_info(input int unsigned idx,
                                      input int unsigned nref,
                                      input logic [2:0] pre_u,
                                      input logic [2:0] gap_u,
                                      input logic [2:0] fin_u);
    step_t s;
    s.issue = 1'b1;
    s.bcast = 1'b1;
    s.cmd   = CMD_NOP;
    s.word  = WORD_NONE;
    s.units = gap_u;
    if (idx == 0) begin
      s.issue = 1'b0;
      s.bcast = 1'b0;
      s.units = pre_u;
    end else if (idx == 1) begin
      s.cmd = CMD_NOP;
    end else if (idx == 2 || idx == 5) begin
      s.cmd = CMD_PRE_ALL;
    end else if (idx == 3) begin
      s.cmd  = CMD_EMRS;
      s.word = WORD_EXT;
    end else if (idx == 4) begin
      s.cmd   = CMD_MRS;
      s.word  = WORD_MODE_RST;
      s.units = 3'd0;
    end else if (idx < 6 + nref) begin
      s.cmd = CMD_AUTO_REF;
    end else if (idx == 6 + nref) begin
      s.cmd   = CMD_MRS;
      s.word  = WORD_MODE_RUN;
      s.units = 3'd0;
    end else if (idx == 7 + nref) begin
      s.cmd   = CMD_NORMAL;
      s.bcast = 1'b0;
    end else begin
      s.issue = 1'b0;
      s.bcast = 1'b0;
      s.units = fin_u;
    end
    return s;
  endfunction

endpackage

// File: rtl/ddr_unit_timer.sv
module ddr_unit_timer #(
  parameter int CYC_PER_US  = 100,
  parameter int US_PER_UNIT = 200,
  parameter int UNITS_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [UNITS_W-1:0] units_i,
  output logic               done_o
);
  localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int US_W  = (US_PER_UNIT > 1) ? $clog2(US_PER_UNIT) : 1;
  localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(CYC_PER_US - 1);
  localparam logic [US_W-1:0]  US_TOP  = US_W'(US_PER_UNIT - 1);

  logic [CYC_W-1:0]   cyc_q;
  logic [US_W-1:0]    us_q;
  logic [UNITS_W-1:0] unit_q;
  logic               run_q;

  assign done_o = run_q && (cyc_q == '0) && (us_q == '0) && (unit_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      us_q   <= '0;
      unit_q <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      cyc_q  <= CYC_TOP;
      us_q   <= US_TOP;
      unit_q <= units_i - UNITS_W'(1);
      run_q  <= 1'b1;
    end else if (run_q) begin
      if (done_o) begin
        run_q <= 1'b0;
      end else if (cyc_q != '0) begin
        cyc_q <= cyc_q - CYC_W'(1);
      end else begin
        cyc_q <= CYC_TOP;
        if (us_q != '0) begin
          us_q <= us_q - US_W'(1);
        end else begin
          us_q   <= US_TOP;
          unit_q <= unit_q - UNITS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ddr_rank_walker.sv
module ddr_rank_walker #(
  parameter int NUM_RANKS = 4,
  parameter int BND_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       adv_i,
  input  logic [NUM_RANKS*BND_W-1:0] rank_end_i,
  output logic                       hit_o,
  output logic                       last_o,
  output logic [NUM_RANKS-1:0]       sel_o,
  output logic [BND_W-1:0]           base_o
);
  localparam int IDX_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_RANKS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [BND_W-1:0] run_q;
  logic [BND_W-1:0] end_cur;

  assign end_cur = rank_end_i[int'(idx_q)*BND_W +: BND_W];
  assign hit_o   = end_cur > run_q;
  assign last_o  = idx_q == IDX_LAST;
  assign base_o  = run_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_sel
    assign sel_o[r] = hit_o && (idx_q == IDX_W'(r));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      idx_q <= '0;
      run_q <= '0;
    end else if (adv_i) begin
      if (last_o) begin
        idx_q <= '0;
        run_q <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        if (hit_o) run_q <= end_cur;
      end
    end
  end
endmodule

// File: rtl/ddr_mode_addr.sv
module ddr_mode_addr
  import ddr_init_pkg::*;
#(
  parameter int          OFF_W       = 25,
  parameter logic [11:0] EXT_WORD    = 12'h000,
  parameter int          DLL_RST_BIT = 8
) (
  input  word_sel_e        sel_i,
  input  logic [11:0]      mode_word_i,
  output logic [OFF_W-1:0] off_o
);
  logic [11:0] word;

  always_comb begin
    unique case (sel_i)
      WORD_EXT:      word = EXT_WORD;
      WORD_MODE_RST: word = mode_word_i | (12'd1 << DLL_RST_BIT);
      WORD_MODE_RUN: word = mode_word_i & ~(12'd1 << DLL_RST_BIT);
      default:       word = 12'h000;
    endcase
    off_o        = '0;
    off_o[13]    = word[11];
    off_o[12:3]  = word[9:0];
  end
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int          NUM_RANKS   = 4,
  parameter int          BND_W       = 8,
  parameter int          RANK_SHIFT  = 25,
  parameter int          CLKS_PER_US = 100,
  parameter int          US_PER_UNIT = 200,
  parameter int          N_REFRESH   = 8,
  parameter int          PRE_UNITS   = 2,
  parameter int          GAP_UNITS   = 3,
  parameter int          FINAL_UNITS = 5,
  parameter logic [11:0] EXT_WORD    = 12'h000,
  parameter int          DLL_RST_BIT = 8,
  localparam int         ADDR_W      = BND_W + RANK_SHIFT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [NUM_RANKS*BND_W-1:0] rank_end_i,
  input  logic [11:0]                mode_word_i,
  output logic                       cmd_vld_o,
  output logic [2:0]                 cmd_o,
  output logic [NUM_RANKS-1:0]       rank_sel_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic                       init_done_o,
  output logic                       ready_o,
  output logic                       busy_o
);
  localparam int N_STEPS = N_REFRESH + 9;
  localparam int STEP_W  = $clog2(N_STEPS + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N_STEPS - 1);
  localparam logic [STEP_W-1:0] STEP_FLAG = STEP_W'(N_STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_READY} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  step_t             info;
  logic              in_issue, bc_now, issue_end, start_go, step_adv;
  logic              tmr_load, tmr_done;
  logic              w_hit, w_last;
  logic [NUM_RANKS-1:0] w_sel;
  logic [BND_W-1:0]  w_base;
  logic [RANK_SHIFT-1:0] mode_off;

  assign info      = step_info(int'(step_q), N_REFRESH, 3'(PRE_UNITS),
                               3'(GAP_UNITS), 3'(FINAL_UNITS));
  assign in_issue  = state_q == ST_ISSUE;
  assign bc_now    = in_issue && info.issue && info.bcast;
  assign issue_end = in_issue && (!bc_now || w_last);
  assign start_go  = start_i && (state_q == ST_IDLE || state_q == ST_READY);
  assign tmr_load  = issue_end && (info.units != 3'd0);
  assign step_adv  = (issue_end && info.units == 3'd0) ||
                     (state_q == ST_WAIT && tmr_done);

  ddr_unit_timer #(
    .CYC_PER_US (CLKS_PER_US),
    .US_PER_UNIT(US_PER_UNIT),
    .UNITS_W    (3)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .units_i(info.units),
    .done_o (tmr_done)
  );

  ddr_rank_walker #(
    .NUM_RANKS(NUM_RANKS),
    .BND_W    (BND_W)
  ) walker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_go),
    .adv_i     (bc_now),
    .rank_end_i(rank_end_i),
    .hit_o     (w_hit),
    .last_o    (w_last),
    .sel_o     (w_sel),
    .base_o    (w_base)
  );

  ddr_mode_addr #(
    .OFF_W      (RANK_SHIFT),
    .EXT_WORD   (EXT_WORD),
    .DLL_RST_BIT(DLL_RST_BIT)
  ) mode_i (
    .sel_i      (info.word),
    .mode_word_i(mode_word_i),
    .off_o      (mode_off)
  );

  always_comb begin
    cmd_vld_o  = in_issue && info.issue && (!info.bcast || w_hit);
    cmd_o      = cmd_vld_o ? info.cmd : 3'd0;
    rank_sel_o = bc_now ? w_sel : '0;
    addr_o     = (bc_now && w_hit) ? {w_base, mode_off} : '0;
  end

  assign init_done_o = done_q;
  assign ready_o     = state_q == ST_READY;
  assign busy_o      = state_q == ST_ISSUE || state_q == ST_WAIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else if (start_go) begin
      state_q <= ST_ISSUE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else if (step_adv) begin
      if (step_q == STEP_LAST) begin
        state_q <= ST_READY;
      end else begin
        state_q <= ST_ISSUE;
        step_q  <= step_q + STEP_W'(1);
        if (step_q + STEP_W'(1) == STEP_FLAG) done_q <= 1'b1;
      end
    end else if (tmr_load) begin
      state_q <= ST_WAIT;
    end
  end
endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
  parameter int NUM_RANKS  = 4,
  parameter int ADDR_W     = 33,
  parameter int RANK_SHIFT = 25
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 cmd_vld_o,
  input logic [2:0]           cmd_o,
  input logic [NUM_RANKS-1:0] rank_sel_o,
  input logic [ADDR_W-1:0]    addr_o,
  input logic                 init_done_o,
  input logic                 ready_o,
  input logic                 busy_o
);
  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> (cmd_o != 3'd0 && cmd_o != 3'd5));
  p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> busy_o);
  p_rank_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_o != 3'd7) |-> $countones(rank_sel_o) == 1);
  p_quiet_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld_o |-> (rank_sel_o == '0 && addr_o == '0 && cmd_o == 3'd0));
  p_mode_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && (cmd_o == 3'd3 || cmd_o == 3'd4)) |->
      (addr_o[2:0] == 3'd0 && addr_o[RANK_SHIFT-1:14] == '0));
  p_plain_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_o != 3'd3 && cmd_o != 3'd4) |->
      addr_o[RANK_SHIFT-1:0] == '0);
  p_local_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_o == 3'd7) |-> (rank_sel_o == '0 && addr_o == '0));
  p_ready_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (init_done_o && !busy_o));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || ready_o));
  p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done_o) |-> $past(start_i));
endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
  .NUM_RANKS (NUM_RANKS),
  .ADDR_W    (ADDR_W),
  .RANK_SHIFT(RANK_SHIFT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .cmd_vld_o  (cmd_vld_o),
  .cmd_o      (cmd_o),
  .rank_sel_o (rank_sel_o),
  .addr_o     (addr_o),
  .init_done_o(init_done_o),
  .ready_o    (ready_o),
  .busy_o     (busy_o)
);

// File: tb/ddr_pwrup_seq_tb.sv
module ddr_pwrup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int BW = 8;
  localparam int CPU = 1;
  localparam int UPU = 4;
  localparam int UNIT = CPU * UPU;
  localparam int AW = BW + 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NR*BW-1:0] rank_end_i = '0;
  logic [11:0] mode_word_i = 12'h062;
  logic cmd_vld_o;
  logic [2:0] cmd_o;
  logic [NR-1:0] rank_sel_o;
  logic [AW-1:0] addr_o;
  logic init_done_o, ready_o, busy_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int start_cyc = 0;
  bit run_on = 1'b0;

  int exp_n, got_n, exp_ic, exp_rd, got_ic, got_rd;
  int exp_t[64];
  int got_t[64];
  logic [2:0] exp_c[64];
  logic [2:0] got_c[64];
  logic [NR-1:0] exp_s[64];
  logic [NR-1:0] got_s[64];
  logic [AW-1:0] exp_a[64];
  logic [AW-1:0] got_a[64];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_pwrup_seq #(.NUM_RANKS(NR), .BND_W(BW), .CLKS_PER_US(CPU),
                  .US_PER_UNIT(UPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rank_end_i(rank_end_i),
    .mode_word_i(mode_word_i), .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o),
    .rank_sel_o(rank_sel_o), .addr_o(addr_o), .init_done_o(init_done_o),
    .ready_o(ready_o), .busy_o(busy_o));

  always @(negedge clk) begin
    int t;
    t = cyc - start_cyc + 1;
    if (run_on && t >= 1) begin
      if (cmd_vld_o && got_n < 64) begin
        got_t[got_n] = t; got_c[got_n] = cmd_o;
        got_s[got_n] = rank_sel_o; got_a[got_n] = addr_o;
        got_n++;
      end
      if (init_done_o && got_ic < 0) got_ic = t;
      if (ready_o && got_rd < 0) got_rd = t;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mode_off(input logic [11:0] w);
    return (AW'(w[11]) << 13) | (AW'(w[9:0]) << 3);
  endfunction

  // Timeline model from R2, R3, R4, R5, R6, R7, R8
  task automatic build_exp(input logic [NR*BW-1:0] ends, input logic [11:0] m);
    int t;
    exp_n = 0;
    t = 1;
    for (int s = 0; s < 17; s++) begin
      int units;
      bit bc, loc, md;
      logic [2:0] c;
      logic [11:0] w;
      bc = 1'b0; loc = 1'b0; md = 1'b0; c = 3'd0; w = 12'h000; units = 3;
      if (s == 0) units = 2;
      else if (s == 1) begin bc = 1; c = 3'd1; end
      else if (s == 2 || s == 5) begin bc = 1; c = 3'd2; end
      else if (s == 3) begin bc = 1; c = 3'd4; md = 1; w = 12'h000; end
      else if (s == 4) begin bc = 1; c = 3'd3; md = 1; w = m | 12'h100; units = 0; end
      else if (s < 14) begin bc = 1; c = 3'd6; end
      else if (s == 14) begin bc = 1; c = 3'd3; md = 1; w = m & ~12'h100; units = 0; end
      else if (s == 15) begin loc = 1; c = 3'd7; end
      else units = 5;
      if (s == 16) exp_ic = t;
      if (bc) begin
        logic [BW-1:0] run;
        run = '0;
        for (int r = 0; r < NR; r++) begin
          logic [BW-1:0] e;
          e = ends[r*BW +: BW];
          if (e > run) begin
            exp_t[exp_n] = t + r; exp_c[exp_n] = c;
            exp_s[exp_n] = NR'(1) << r;
            exp_a[exp_n] = (AW'(run) << 25) | (md ? mode_off(w) : '0);
            exp_n++;
            run = e;
          end
        end
        t += NR + units * UNIT;
      end else begin
        if (loc) begin
          exp_t[exp_n] = t; exp_c[exp_n] = c; exp_s[exp_n] = '0;
          exp_a[exp_n] = '0; exp_n++;
        end
        t += 1 + units * UNIT;
      end
    end
    exp_rd = t;
  endtask

  task automatic run_one(input logic [NR*BW-1:0] ends, input logic [11:0] m,
                         input int extra_at);
    int n;
    build_exp(ends, m);
    rank_end_i = ends;
    mode_word_i = m;
    got_n = 0; got_ic = -1; got_rd = -1;
    @(negedge clk);
    start_cyc = cyc + 1;
    run_on = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !ready_o && !init_done_o, "R9", "restart clears flags",
        {busy_o, ready_o, init_done_o}, 3'b100);
    n = 1;
    while (!ready_o && n < 4000) begin
      start_i = (n == extra_at);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    @(negedge clk);
    run_on = 1'b0;
    chk(got_n == exp_n, "R4", "strobe count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_t[i] == exp_t[i], "R3", "strobe cycle", got_t[i], exp_t[i]);
      chk(got_c[i] == exp_c[i], "R1 R2", "command code", got_c[i], exp_c[i]);
      chk(got_s[i] == exp_s[i], exp_c[i] == 3'd7 ? "R7" : "R4", "rank select",
          got_s[i], exp_s[i]);
      chk(got_a[i] == exp_a[i], "R5 R6", "address", got_a[i], exp_a[i]);
    end
    chk(got_ic == exp_ic, "R8", "done flag cycle", got_ic, exp_ic);
    chk(got_rd == exp_rd, "R8", "ready cycle", got_rd, exp_rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({cmd_vld_o, cmd_o, rank_sel_o, addr_o, init_done_o, ready_o, busy_o} == '0,
        "R10", "outputs in reset", cmd_vld_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cmd_vld_o, cmd_o, rank_sel_o, addr_o, init_done_o, ready_o, busy_o} == '0,
        "R10", "outputs after reset", busy_o, 0);
    // sweep all boundary patterns with values 0..3 per rank
    for (int p = 0; p < 256; p++) begin
      logic [NR*BW-1:0] e;
      e = '0;
      for (int r = 0; r < NR; r++) e[r*BW +: BW] = BW'((p >> (2 * r)) & 3);
      run_one(e, 12'h062, 0);
    end
    // wide boundaries and other mode words
    run_one({8'd200, 8'd90, 8'd17, 8'd4}, 12'hABC, 0);
    run_one({8'd255, 8'd0, 8'd128, 8'd1}, 12'h9FF, 0);
    // start while busy must be ignored (R9)
    run_one({8'd8, 8'd6, 8'd4, 8'd2}, 12'h062, 37);
    run_one({8'd8, 8'd6, 8'd4, 8'd2}, 12'h062, 150);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule